// File: doc/BRIEF.md
# Single-Cycle Row Write-After-Read Sequencer

This block performs a write of one narrow word into a wide memory row in a single access, for a memory whose cells cannot tolerate column multiplexing. A write to one word still has to rewrite every cell of the row. An accepted request first raises the read wordline for a programmed number of fast-clock ticks, and the whole addressed row is captured into a row-wide holding latch at the end of that pulse. After a programmed idle gap, the new word is merged into its lane of the latched row. The write wordline then pulses for a programmed number of ticks, and the complete merged row is stored back. Half-selected cells therefore receive their own values again, not a disturbed state.

The three timing margins (read pulse, gap, write pulse) are external inputs in fast-clock ticks. They are sampled when a request is accepted. A programmed value of zero is treated as one tick, so the two wordlines can never be active together or back to back. The row store is a behavioural register model. After a sequence, the latch keeps the merged row and its row index, so a following read of that row can be served from the latch.

Top module: `war_seq`

## Requirements
- R1: One cycle after a request is accepted in idle, `busy_o` rises. It stays high for exactly r+g+w+2 cycles, where r, g and w are the effective read width, gap and write width. `done_o` is high only in the last of those cycles.
- R2: `rwl_o` is high for exactly r cycles, starting in the first cycle after acceptance. r is `rd_width_i` sampled at acceptance, with 0 taken as 1.
- R3: The full addressed row, as stored at acceptance, appears on `latch_row_o` in the first cycle after the read pulse ends.
- R4: `rwl_o` and `wwl_o` are never high together. The write pulse starts g+1 cycles after the read pulse ends: the gap, then one merge cycle. g is `gap_i` sampled at acceptance, with 0 taken as 1.
- R5: `wwl_o` is high for exactly w cycles. w is `wr_width_i` sampled at acceptance, with 0 taken as 1.
- R6: The address splits into row index = `addr_i[5:3]` and word lane = `addr_i[2:0]`. From the first write-pulse cycle, `latch_row_o` equals the captured row with bits [16*lane+15:16*lane] replaced by `wdata_i`. All other bits are unchanged.
- R7: At the end of the write pulse, all 128 bits of the merged row are stored into the addressed row. A later sequence on that row captures exactly that value.
- R8: A request while `busy_o` is high has no effect. This covers its address, data and margins: timing, latch contents and stored rows all follow the running sequence only.
- R9: After the sequence ends, and until the next accepted request, `latch_row_o` holds the merged row and `latch_row_idx_o` holds its row index.
- R10: After reset, `busy_o`, `rwl_o`, `wwl_o` and `done_o` are low, the latch reads zero and every stored row is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; margins are counted in its ticks |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write-after-read request, taken only when idle |
| addr_i | input | 6 | Row index [5:3], word lane [2:0] |
| wdata_i | input | 16 | Word to merge into the row |
| rd_width_i | input | 4 | Read wordline pulse width in ticks (0 acts as 1) |
| gap_i | input | 4 | Idle ticks after the read pulse (0 acts as 1) |
| wr_width_i | input | 4 | Write wordline pulse width in ticks (0 acts as 1) |
| busy_o | output | 1 | Sequence in progress, including its final cycle |
| rwl_o | output | 1 | Read wordline pulse |
| wwl_o | output | 1 | Write wordline pulse |
| done_o | output | 1 | Final cycle of a sequence |
| latch_row_o | output | 128 | Row holding latch contents |
| latch_row_idx_o | output | 3 | Row index the latch belongs to |

## Verification
Each result has a fixed due cycle, counted from the clock edge that accepts the request; cycle k is the k-th cycle after that edge. The wordlines, busy and done are compared every cycle against windows computed from r, g and w. The captured row is due at cycle r. The merged row is due at cycle r+g+1. The held latch is due after busy falls. All sampling happens on the falling clock edge, away from the edge where the outputs change. A sweep over all combinations of margins 0 to 3, plus extremes at 15, runs across revisited rows. Half of the operations keep injecting conflicting requests throughout the busy window.

// File: rtl/war_pkg.sv
package war_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD,
      S_GAP,
      S_MRG,
      S_WR,
      S_DONE
   } war_state_e;

   // Margin value with zero promoted to one tick.
   function automatic logic [7:0] at_least_one(input logic [7:0] v);
      return (v == 8'd0) ? 8'd1 : v;
   endfunction

endpackage

// File: rtl/war_phase_cnt.sv
module war_phase_cnt #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   assign last_o = (cnt_q == limit_i - 1'b1);

   // R2 / R5: a phase never runs past its limit
   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && limit_i != '0) |-> (cnt_q < limit_i))
      else $error("phase counter beyond limit");

endmodule

// File: rtl/war_row_store.sv
module war_row_store #(
   parameter int  ROWS      = 8,
   parameter int  ROW_W     = 128,
   parameter bit  ZERO_INIT = 1'b1,
   localparam int ROW_AW    = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_AW-1:0] idx_i,
   input  logic              we_i,
   input  logic [ROW_W-1:0]  wrow_i,
   output logic [ROW_W-1:0]  rrow_o
);

   logic [ROW_W-1:0] mem [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      if (ZERO_INIT) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   mem[r] <= '0;
            else if (we_i && idx_i == ROW_AW'(r))          mem[r] <= wrow_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we_i && idx_i == ROW_AW'(r)) mem[r] <= wrow_i;
         end
      end
   end

   assign rrow_o = mem[idx_i];

   // R7: the whole row lands in the addressed entry
   p_whole_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem[$past(idx_i)] == $past(wrow_i)))
      else $error("row write-back incomplete");

endmodule

// File: rtl/war_lane_merge.sv
module war_lane_merge #(
   parameter int  ROW_W  = 128,
   parameter int  WORD_W = 16,
   localparam int LANES  = ROW_W / WORD_W,
   localparam int SEL_W  = $clog2(LANES)
) (
   input  logic [ROW_W-1:0]  row_i,
   input  logic [SEL_W-1:0]  lane_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [ROW_W-1:0]  row_o
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign row_o[l*WORD_W +: WORD_W] =
         (lane_i == SEL_W'(l)) ? word_i : row_i[l*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/war_seq.sv
module war_seq
   import war_pkg::*;
#(
   parameter int  ROWS      = 8,
   parameter int  ROW_W     = 128,
   parameter int  WORD_W    = 16,
   parameter int  MARGIN_W  = 4,
   parameter bit  ZERO_INIT = 1'b1,
   localparam int LANES     = ROW_W / WORD_W,
   localparam int SEL_W     = $clog2(LANES),
   localparam int ROW_AW    = $clog2(ROWS),
   localparam int ADDR_W    = ROW_AW + SEL_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [WORD_W-1:0]   wdata_i,
   input  logic [MARGIN_W-1:0] rd_width_i,
   input  logic [MARGIN_W-1:0] gap_i,
   input  logic [MARGIN_W-1:0] wr_width_i,
   output logic                busy_o,
   output logic                rwl_o,
   output logic                wwl_o,
   output logic                done_o,
   output logic [ROW_W-1:0]    latch_row_o,
   output logic [ROW_AW-1:0]   latch_row_idx_o
);

   // elaboration-time parameter checks
   if (ROW_W % WORD_W != 0)          begin : g_chk_div  $error("ROW_W must be a multiple of WORD_W"); end
   if ((1 << SEL_W) != LANES)        begin : g_chk_lane $error("lane count must be a power of two"); end
   if ((1 << ROW_AW) != ROWS)        begin : g_chk_rows $error("ROWS must be a power of two"); end
   if (MARGIN_W < 1 || MARGIN_W > 8) begin : g_chk_mw   $error("MARGIN_W must be 1..8"); end

   war_state_e          state_q, state_d;
   logic [ROW_AW-1:0]   row_q;
   logic [SEL_W-1:0]    lane_q;
   logic [WORD_W-1:0]   word_q;
   logic [MARGIN_W-1:0] rd_q, gap_q, wr_q;
   logic [ROW_W-1:0]    latch_q;
   logic [ROW_W-1:0]    stored_row;
   logic [ROW_W-1:0]    merged_row;
   logic [MARGIN_W-1:0] limit;
   logic                phase_last;
   logic                accept;
   logic                cnt_clear;
   logic                store_we;

   assign accept = req_i && (state_q == S_IDLE);

   // next state
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:  if (req_i)      state_d = S_RD;
         S_RD:    if (phase_last) state_d = S_GAP;
         S_GAP:   if (phase_last) state_d = S_MRG;
         S_MRG:                   state_d = S_WR;
         S_WR:    if (phase_last) state_d = S_DONE;
         S_DONE:                  state_d = S_IDLE;
         default:                 state_d = S_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_q)
         S_RD:    limit = rd_q;
         S_GAP:   limit = gap_q;
         S_WR:    limit = wr_q;
         default: limit = MARGIN_W'(1);
      endcase
   end

   assign cnt_clear = (state_d != state_q) || (state_q == S_IDLE);

   war_phase_cnt #(.CNT_W(MARGIN_W)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cnt_clear),
      .limit_i (limit),
      .last_o  (phase_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_IDLE;
      else        state_q <= state_d;
   end

   // request capture: margins sampled once, zero promoted to one tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         lane_q <= '0;
         word_q <= '0;
         rd_q   <= MARGIN_W'(1);
         gap_q  <= MARGIN_W'(1);
         wr_q   <= MARGIN_W'(1);
      end else if (accept) begin
         row_q  <= addr_i[ADDR_W-1:SEL_W];
         lane_q <= addr_i[SEL_W-1:0];
         word_q <= wdata_i;
         rd_q   <= MARGIN_W'(at_least_one(8'(rd_width_i)));
         gap_q  <= MARGIN_W'(at_least_one(8'(gap_i)));
         wr_q   <= MARGIN_W'(at_least_one(8'(wr_width_i)));
      end
   end

   war_row_store #(
      .ROWS      (ROWS),
      .ROW_W     (ROW_W),
      .ZERO_INIT (ZERO_INIT)
   ) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx_i  (row_q),
      .we_i   (store_we),
      .wrow_i (latch_q),
      .rrow_o (stored_row)
   );

   war_lane_merge #(
      .ROW_W  (ROW_W),
      .WORD_W (WORD_W)
   ) i_merge (
      .row_i  (latch_q),
      .lane_i (lane_q),
      .word_i (word_q),
      .row_o  (merged_row)
   );

   // row latch: capture at end of read pulse, merge in the merge cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              latch_q <= '0;
      else if (state_q == S_RD && phase_last)  latch_q <= stored_row;
      else if (state_q == S_MRG)               latch_q <= merged_row;
   end

   assign store_we        = (state_q == S_WR) && phase_last;
   assign rwl_o           = (state_q == S_RD);
   assign wwl_o           = (state_q == S_WR);
   assign done_o          = (state_q == S_DONE);
   assign busy_o          = (state_q != S_IDLE);
   assign latch_row_o     = latch_q;
   assign latch_row_idx_o = row_q;

   // R4: wordlines exclusive
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rwl_o && wwl_o))
      else $error("wordlines overlap");

   // R4: read pulse always followed by the gap
   p_gap_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rwl_o) |-> (state_q == S_GAP))
      else $error("no gap after read pulse");

   // R6: write pulse preceded by the merge cycle
   p_merge_before_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wwl_o) |-> ($past(state_q) == S_MRG))
      else $error("write pulse without merge");

   // R8: captured request frozen while busy
   p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(row_q) && $stable(lane_q) && $stable(word_q) && $stable(rd_q)))
      else $error("request taken while busy");

   // R1: done ends the busy window
   p_done_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o)
      else $error("busy after done");

   // R9: latch held while idle
   p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE) |=> $stable(latch_q))
      else $error("latch changed while idle");

endmodule

// File: tb/test_war_seq.sv
module test_war_seq;

   localparam int CLK_P = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_i = 1'b0;
   logic [5:0]   addr_i = '0;
   logic [15:0]  wdata_i = '0;
   logic [3:0]   rd_width_i = '0;
   logic [3:0]   gap_i = '0;
   logic [3:0]   wr_width_i = '0;
   logic         busy_o, rwl_o, wwl_o, done_o;
   logic [127:0] latch_row_o;
   logic [2:0]   latch_row_idx_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [127:0] ref_mem [8];

   always #(CLK_P/2) clk = ~clk;

   war_seq i_war_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_i           (req_i),
      .addr_i          (addr_i),
      .wdata_i         (wdata_i),
      .rd_width_i      (rd_width_i),
      .gap_i           (gap_i),
      .wr_width_i      (wr_width_i),
      .busy_o          (busy_o),
      .rwl_o           (rwl_o),
      .wwl_o           (wwl_o),
      .done_o          (done_o),
      .latch_row_o     (latch_row_o),
      .latch_row_idx_o (latch_row_idx_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_op(input int rdw, input int gw, input int ww, input int a,
                         input logic [15:0] d, input bit noisy);
      int r, g, w, total, row, lane;
      int bad_rwl, bad_wwl, bad_busy;
      logic [127:0] merged;
      r = (rdw == 0) ? 1 : rdw;
      g = (gw == 0) ? 1 : gw;
      w = (ww == 0) ? 1 : ww;
      total = r + g + w + 2;
      row = a / 8;
      lane = a % 8;
      merged = ref_mem[row];
      merged[lane*16 +: 16] = d;
      bad_rwl = 0; bad_wwl = 0; bad_busy = 0;

      @(negedge clk);
      req_i = 1'b1; addr_i = 6'(a); wdata_i = d;
      rd_width_i = 4'(rdw); gap_i = 4'(gw); wr_width_i = 4'(ww);

      for (int k = 0; k <= total; k++) begin
         @(negedge clk);
         if (rwl_o !== (k < r)) bad_rwl++;
         if (wwl_o !== (k >= r + g + 1 && k < r + g + 1 + w)) bad_wwl++;
         if (busy_o !== (k < total) || done_o !== (k == total - 1)) bad_busy++;
         if (k == r)
            chk(latch_row_o === ref_mem[row], "R3/R7 captured row", latch_row_o, ref_mem[row]);
         if (k == r + g + 1)
            chk(latch_row_o === merged, "R6 merged row", latch_row_o, merged);
         if (noisy && k <= total - 1) begin
            req_i = 1'b1;
            addr_i = 6'((a + 3 * k + 1) % 64);
            wdata_i = ~d ^ 16'(k);
            rd_width_i = 4'(15 - k % 16); gap_i = 4'(k % 16); wr_width_i = 4'((k * 7) % 16);
         end else begin
            req_i = 1'b0;
         end
      end
      req_i = 1'b0;
      ref_mem[row] = merged;

      chk(bad_rwl == 0, "R2 read pulse window", 128'(bad_rwl), 128'd0);
      chk(bad_wwl == 0, "R4/R5 write pulse window", 128'(bad_wwl), 128'd0);
      chk(bad_busy == 0, "R1 busy/done window", 128'(bad_busy), 128'd0);
      if (noisy)
         chk(bad_rwl + bad_wwl + bad_busy == 0, "R8 requests while busy ignored",
             128'(bad_rwl + bad_wwl + bad_busy), 128'd0);

      repeat (2) @(negedge clk);
      chk(latch_row_o === merged, "R9 latch held after done", latch_row_o, merged);
      chk(latch_row_idx_o === 3'(row), "R9 latch row index", 128'(latch_row_idx_o), 128'(row));
   endtask

   initial begin
      for (int i = 0; i < 8; i++) ref_mem[i] = '0;
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0 && rwl_o === 1'b0 && wwl_o === 1'b0 && done_o === 1'b0,
          "R10 reset outputs", 128'({busy_o, rwl_o, wwl_o, done_o}), 128'd0);
      chk(latch_row_o === '0, "R10 reset latch", latch_row_o, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o === 1'b0, "R10 idle after reset", 128'(busy_o), 128'd0);

      // R10 / R7: first visits to fresh rows capture zero (checked inside run_op)
      for (int i = 0; i < 64; i++) begin
         run_op(i / 16, (i / 4) % 4, i % 4, (i * 13 + 5) % 64,
                16'((i * 16'h1f3) ^ 16'h5a55), i[0]);
      end
      run_op(15, 15, 15, 63, 16'hffff, 1'b1);
      run_op(15, 0, 1, 0, 16'h8001, 1'b0);
      run_op(1, 15, 0, 7, 16'h1234, 1'b1);
      run_op(0, 0, 0, 56, 16'hbeef, 1'b0);
      // revisit every row to confirm full-row write-back (R7)
      for (int i = 0; i < 8; i++)
         run_op(1, 1, 1, i * 8 + (i % 8), 16'(16'hc000 + i), 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule